// File: doc/BRIEF.md
# Triple Clock Generator Health Monitor

This block watches three clock generators that should run at the same rate and works out which one has gone wrong. Each generator drives its own counter. Each counter is built from three copies with a bitwise majority vote, so a flipped bit in one copy does not change the count. The counts travel into a common reference clock domain as Gray code through two-flop synchronizers. They are turned back into binary and compared in pairs. Two counts that lie within a small tolerance of each other count as matching.

The comparison runs once every check period. If exactly one count disagrees with the other two, and those two agree with each other, the block blames that generator. It raises a sticky fault flag for it and pulses a reset request to that generator only. If all three counts disagree with each other, it raises a sticky unresolved flag and blames nobody. After any verdict, the block holds all three counters clear together, waits a settling interval, and then starts comparing again from aligned counts. No comparison is judged while a reset request, a clear or the settling interval is in progress.

Top module: `clk_trio_monitor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `fault_o`, `gen_rst_req_o` and `unresolved_o` are all zero.
- R2: When all three generators run at the reference rate, at any phase offsets, counts that differ by at most TOL (default 2) raise no flag and no request.
- R3: If one generator stops, bit i of `fault_o` is set, where bit i belongs to generator i (`gen_clk[i]`). No other fault bit is set.
- R4: If one generator runs at least 30% faster or slower than the other two, its fault bit is set and no other fault bit is set.
- R5: A blamed generator gets one pulse on its own bit of `gen_rst_req_o` that lasts exactly RST_CYC reference cycles (default 4). At most one request bit is high at any time.
- R6: When all three counts disagree with each other, `unresolved_o` is set and no fault bit and no request bit is raised.
- R7: After a verdict, all three counters restart from zero together. A generator that has been restored to the correct rate after its reset is not blamed again.
- R8: Fault bits and `unresolved_o` stay set until `rst`.
- R9: A second generator that fails while the reset and clear sequence of the first is in progress is judged only after monitoring resumes. It is then blamed with its own single request pulse.
- R10: Each voted counter advances by exactly one per edge of its generator outside a clear, and its Gray output changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all outputs are registered on it |
| rst | input | 1 | Synchronous active-high reset in the reference domain |
| gen_clk | input | 3 | The three watched generator clocks; bit i is generator i |
| fault_o | output | 3 | Sticky per-generator fault flags |
| gen_rst_req_o | output | 3 | Per-generator reset request pulses |
| unresolved_o | output | 1 | Sticky flag: all three counts disagree with each other |

## Verification
Two things can happen in the same cycle. The block is busy with the reset request and counter clear for one generator, and a second generator starts to misbehave. To provoke this, the bench restores the first generator and slows a second one in the very cycle it first sees the request. It then checks that the second generator is blamed only after comparisons resume, with its own single pulse. Both fault bits must end up set and the unresolved flag must stay low. The remaining cases come from randomly chosen generators and failure kinds (stopped, fast or slow) injected at random times. There are also directed cases for healthy phase skew and for a three-way disagreement.

// File: rtl/ctm_pkg.sv
`timescale 1ns/100ps
package ctm_pkg;

  typedef enum logic [1:0] {
    ST_CLEAR  = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WATCH  = 2'd2,
    ST_RESET  = 2'd3
  } mon_state_t;

  // Pair agreement bits: [0] gen0~gen1, [1] gen0~gen2, [2] gen1~gen2.
  // Result: [3] unresolved, [2:0] one-hot generator to blame.
  function automatic logic [3:0] judge(input logic [2:0] agree);
    logic [3:0] res;
    res = 4'b0000;
    case (agree)
      3'b100:  res = 4'b0001;  // only gen1~gen2 agree: blame gen0
      3'b010:  res = 4'b0010;  // only gen0~gen2 agree: blame gen1
      3'b001:  res = 4'b0100;  // only gen0~gen1 agree: blame gen2
      3'b000:  res = 4'b1000;  // nobody agrees
      default: res = 4'b0000;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/ctm_tmr_counter.sv
`timescale 1ns/100ps
module ctm_tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             gclk,
  input  logic             clr_i,
  output logic [CNT_W-1:0] gray_o
);

  logic [1:0]       clr_sync_q;
  logic             clr_s;
  logic             armed_q;
  logic [CNT_W-1:0] copy_q [3];
  logic [CNT_W-1:0] voted;
  logic [CNT_W-1:0] gray_q;

  always_ff @(posedge gclk) clr_sync_q <= {clr_sync_q[0], clr_i};
  assign clr_s = clr_sync_q[1];

  always_comb begin
    voted = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) |
            (copy_q[1] & copy_q[2]);
  end

  for (genvar c = 0; c < 3; c++) begin : g_copy
    always_ff @(posedge gclk) begin
      if (clr_s) copy_q[c] <= '0;
      else       copy_q[c] <= voted + 1'b1;
    end
  end

  always_ff @(posedge gclk) begin
    gray_q  <= voted ^ (voted >> 1);
    armed_q <= armed_q | clr_s;
  end

  assign gray_o = gray_q;

  // R10: voted count steps by one per edge away from a clear
  p_count_step_r10: assert property (@(posedge gclk) disable iff (!armed_q)
    (!clr_s && !$past(clr_s)) |-> (voted == $past(voted) + 1'b1));

  // R10: Gray output never moves by more than one bit per edge
  p_gray_one_bit_r10: assert property (@(posedge gclk) disable iff (!armed_q)
    (!clr_s && !$past(clr_s) && !$past(clr_s, 2)) |->
      ($countones(gray_q ^ $past(gray_q)) <= 1));

endmodule

// File: rtl/ctm_count_vote.sv
`timescale 1ns/100ps
module ctm_count_vote #(
  parameter int CNT_W = 8,
  parameter int TOL   = 2
) (
  input  logic                  ref_clk,
  input  logic                  rst,
  input  logic [2:0][CNT_W-1:0] gray_i,
  output logic [2:0]            agree_o
);

  function automatic logic [CNT_W-1:0] to_bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int k = CNT_W - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  function automatic logic near(input logic [CNT_W-1:0] a,
                                input logic [CNT_W-1:0] b);
    logic [CNT_W-1:0] fwd, bwd;
    fwd = a - b;
    bwd = b - a;
    return (fwd <= CNT_W'(TOL)) || (bwd <= CNT_W'(TOL));
  endfunction

  logic [2:0][CNT_W-1:0] bin_w;
  logic [2:0]            agree_q;

  for (genvar g = 0; g < 3; g++) begin : g_lane
    logic [CNT_W-1:0] s1_q, s2_q, bin_q;
    always_ff @(posedge ref_clk) begin
      s1_q  <= gray_i[g];
      s2_q  <= s1_q;
      bin_q <= to_bin(s2_q);
    end
    assign bin_w[g] = bin_q;
  end

  always_ff @(posedge ref_clk) begin
    if (rst) agree_q <= 3'b111;
    else     agree_q <= {near(bin_w[1], bin_w[2]),
                         near(bin_w[0], bin_w[2]),
                         near(bin_w[0], bin_w[1])};
  end

  assign agree_o = agree_q;

endmodule

// File: rtl/ctm_supervisor.sv
`timescale 1ns/100ps
module ctm_supervisor
  import ctm_pkg::*;
#(
  parameter int CLR_CYC    = 4,
  parameter int SETTLE_CYC = 8,
  parameter int CHECK_CYC  = 16,
  parameter int RST_CYC    = 4
) (
  input  logic       ref_clk,
  input  logic       rst,
  input  logic [2:0] agree_i,
  output logic       clr_o,
  output logic [2:0] fault_o,
  output logic [2:0] req_o,
  output logic       unres_o
);

  localparam int LONG_A  = (CLR_CYC > SETTLE_CYC) ? CLR_CYC : SETTLE_CYC;
  localparam int LONG_B  = (CHECK_CYC > RST_CYC) ? CHECK_CYC : RST_CYC;
  localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
  localparam int TW      = $clog2(LONGEST + 1);

  mon_state_t  st_q;
  logic [TW-1:0] tmr_q;
  logic        clr_q;
  logic [2:0]  fault_q, req_q;
  logic        unres_q;
  logic [3:0]  verdict;

  assign verdict = judge(agree_i);

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      st_q    <= ST_CLEAR;
      tmr_q   <= '0;
      clr_q   <= 1'b1;
      fault_q <= '0;
      req_q   <= '0;
      unres_q <= 1'b0;
    end else begin
      case (st_q)
        ST_CLEAR: begin
          if (tmr_q == TW'(CLR_CYC - 1)) begin
            st_q <= ST_SETTLE; tmr_q <= '0; clr_q <= 1'b0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        ST_SETTLE: begin
          if (tmr_q == TW'(SETTLE_CYC - 1)) begin
            st_q <= ST_WATCH; tmr_q <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        ST_WATCH: begin
          if (tmr_q == TW'(CHECK_CYC - 1)) begin
            tmr_q <= '0;
            if (verdict[3]) begin
              unres_q <= 1'b1;
              clr_q   <= 1'b1;
              st_q    <= ST_CLEAR;
            end else if (|verdict[2:0]) begin
              fault_q <= fault_q | verdict[2:0];
              req_q   <= verdict[2:0];
              st_q    <= ST_RESET;
            end
          end else tmr_q <= tmr_q + 1'b1;
        end
        ST_RESET: begin
          if (tmr_q == TW'(RST_CYC - 1)) begin
            req_q <= '0; clr_q <= 1'b1; tmr_q <= '0; st_q <= ST_CLEAR;
          end else tmr_q <= tmr_q + 1'b1;
        end
        default: st_q <= ST_CLEAR;
      endcase
    end
  end

  assign clr_o   = clr_q;
  assign fault_o = fault_q;
  assign req_o   = req_q;
  assign unres_o = unres_q;

  // R5: never more than one generator under reset request
  p_req_onehot_r5: assert property (@(posedge ref_clk) disable iff (rst)
    $onehot0(req_q));

  // R3: a request only targets a generator that is flagged
  p_req_flagged_r3: assert property (@(posedge ref_clk) disable iff (rst)
    ((req_q & fault_q) == req_q));

  // R8: flags never drop outside reset
  p_sticky_r8: assert property (@(posedge ref_clk) disable iff (rst)
    !$past(rst) |-> (((fault_q & $past(fault_q)) == $past(fault_q)) &&
                     (unres_q || !$past(unres_q))));

  // R6: an unresolved verdict issues no request
  p_unres_no_req_r6: assert property (@(posedge ref_clk) disable iff (rst)
    (!$past(rst) && $rose(unres_q)) |-> (req_q == 3'b000));

  // R9: no new blame while a request is in progress
  p_hold_in_reset_r9: assert property (@(posedge ref_clk) disable iff (rst)
    (req_q != 3'b000) |=> (fault_q == $past(fault_q)));

endmodule

// File: rtl/clk_trio_monitor.sv
`timescale 1ns/100ps
module clk_trio_monitor #(
  parameter int CNT_W      = 8,
  parameter int TOL        = 2,
  parameter int CLR_CYC    = 4,
  parameter int SETTLE_CYC = 8,
  parameter int CHECK_CYC  = 16,
  parameter int RST_CYC    = 4
) (
  input  logic       ref_clk,
  input  logic       rst,
  input  logic [2:0] gen_clk,
  output logic [2:0] fault_o,
  output logic [2:0] gen_rst_req_o,
  output logic       unresolved_o
);

  logic [2:0][CNT_W-1:0] gray_w;
  logic [2:0]            agree_w;
  logic                  clr_w;

  for (genvar i = 0; i < 3; i++) begin : g_gen
    ctm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .gclk  (gen_clk[i]),
      .clr_i (clr_w),
      .gray_o(gray_w[i])
    );
  end

  ctm_count_vote #(.CNT_W(CNT_W), .TOL(TOL)) u_vote (
    .ref_clk(ref_clk),
    .rst    (rst),
    .gray_i (gray_w),
    .agree_o(agree_w)
  );

  ctm_supervisor #(
    .CLR_CYC(CLR_CYC), .SETTLE_CYC(SETTLE_CYC),
    .CHECK_CYC(CHECK_CYC), .RST_CYC(RST_CYC)
  ) u_sup (
    .ref_clk(ref_clk),
    .rst    (rst),
    .agree_i(agree_w),
    .clr_o  (clr_w),
    .fault_o(fault_o),
    .req_o  (gen_rst_req_o),
    .unres_o(unresolved_o)
  );

endmodule

// File: tb/clk_trio_monitor_test.sv
`timescale 1ns/100ps
module clk_trio_monitor_test;

  localparam int RST_CYC = 4;

  logic       ref_clk = 1'b0;
  logic       rst = 1'b1;
  logic       gc0, gc1, gc2;
  logic [2:0] fault_o, gen_rst_req_o;
  logic       unresolved_o;

  real      hp [3] = '{5.0, 5.0, 5.0};
  bit [2:0] run = 3'b111;

  int checks = 0, failures = 0;
  int pulses [3];
  int highs  [3];
  logic [2:0] prev_req;
  int chain_to;

  clk_trio_monitor uut (
    .ref_clk(ref_clk), .rst(rst), .gen_clk({gc2, gc1, gc0}),
    .fault_o(fault_o), .gen_rst_req_o(gen_rst_req_o),
    .unresolved_o(unresolved_o)
  );

  always #5 ref_clk = ~ref_clk;

  initial begin gc0 = 1'b0; #1; forever begin #(hp[0]); if (run[0]) gc0 = ~gc0; end end
  initial begin gc1 = 1'b0; #3; forever begin #(hp[1]); if (run[1]) gc1 = ~gc1; end end
  initial begin gc2 = 1'b0; #7; forever begin #(hp[2]); if (run[2]) gc2 = ~gc2; end end

  function automatic logic [2:0] onehot(input int i);
    return 3'(1 << i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic heal(input int i);
    run[i] = 1'b1;
    hp[i]  = 5.0;
  endtask

  task automatic clear_stats();
    for (int i = 0; i < 3; i++) begin pulses[i] = 0; highs[i] = 0; end
    prev_req = 3'b000;
  endtask

  // Observe n cycles; restore a generator when it is asked to reset.
  task automatic observe(input int n);
    repeat (n) begin
      @(negedge ref_clk);
      for (int i = 0; i < 3; i++) begin
        if (gen_rst_req_o[i]) begin
          highs[i]++;
          if (!prev_req[i]) begin
            pulses[i]++;
            heal(i);
            if (chain_to >= 0) begin
              hp[chain_to] = 7.0;  // second generator slows in the same cycle
              chain_to = -1;
            end
          end
        end
      end
      prev_req = gen_rst_req_o;
    end
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) heal(i);
    repeat (4) @(negedge ref_clk);
    rst = 1'b0;
    clear_stats();
  endtask

  initial begin
    #(10 * 150000);
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    chain_to = -1;
    clear_stats();
    repeat (3) @(negedge ref_clk);
    chk("R1 fault in reset", 32'(fault_o), 0);
    chk("R1 request in reset", 32'(gen_rst_req_o), 0);
    chk("R1 unresolved in reset", 32'(unresolved_o), 0);
    rst = 1'b0;
    @(negedge ref_clk);
    chk("R1 fault after release", 32'(fault_o), 0);

    // R2 / R10: healthy, skewed phases
    observe(800);
    chk("R2 R10 healthy faults", 32'(fault_o), 0);
    chk("R2 healthy pulses", 32'(pulses[0] + pulses[1] + pulses[2]), 0);
    chk("R2 healthy unresolved", 32'(unresolved_o), 0);

    // R3 / R4 / R5 / R7 / R8: random single-generator failures
    for (int t = 0; t < 8; t++) begin
      int idx, kind;
      string tag;
      idx  = $urandom_range(0, 2);
      kind = (t < 3) ? t : $urandom_range(0, 2);
      do_reset();
      observe($urandom_range(60, 160));
      if (kind == 0) begin run[idx] = 1'b0; tag = "R3"; end
      else if (kind == 1) begin hp[idx] = 7.0; tag = "R4"; end
      else begin hp[idx] = 3.5; tag = "R4"; end
      observe(500);
      chk({tag, " blamed generator"}, 32'(fault_o), 32'(onehot(idx)));
      chk("R5 single pulse on blamed", 32'(pulses[idx]), 1);
      chk("R5 pulse length", 32'(highs[idx]), RST_CYC);
      chk("R5 R7 no pulse elsewhere",
          32'(pulses[0] + pulses[1] + pulses[2] - pulses[idx]), 0);
      chk("R6 no unresolved on single fault", 32'(unresolved_o), 0);
      observe(300);
      chk("R7 restored not blamed again", 32'(pulses[idx]), 1);
      chk("R8 flag sticky", 32'(fault_o), 32'(onehot(idx)));
    end

    do_reset();
    @(negedge ref_clk);
    chk("R8 flags cleared by reset", 32'(fault_o), 0);

    // R6: three-way disagreement, applied across reset
    @(negedge ref_clk);
    rst = 1'b1;
    hp[0] = 8.0; hp[1] = 2.5; hp[2] = 5.0;
    repeat (4) @(negedge ref_clk);
    rst = 1'b0;
    clear_stats();
    observe(400);
    chk("R6 unresolved raised", 32'(unresolved_o), 1);
    chk("R6 no fault bit", 32'(fault_o), 0);
    chk("R6 no request", 32'(pulses[0] + pulses[1] + pulses[2]), 0);
    for (int i = 0; i < 3; i++) heal(i);
    observe(100);
    chk("R8 unresolved sticky", 32'(unresolved_o), 1);

    // R9: second failure arrives during the first reset sequence
    do_reset();
    observe(90);
    chain_to = 2;
    run[1] = 1'b0;
    observe(800);
    chk("R9 both blamed", 32'(fault_o), 32'(3'b110));
    chk("R9 first pulse", 32'(pulses[1]), 1);
    chk("R9 second pulse", 32'(pulses[2]), 1);
    chk("R9 untouched generator", 32'(pulses[0]), 0);
    chk("R9 not unresolved", 32'(unresolved_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule